// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Tracker

This block keeps the load-linked reservations that hardware thread contexts hold on one cache line. Every request carries a context number, an operation and an inclusive byte range within the line. A load-linked request records a reservation for its context. A store, or a store-conditional that succeeds, removes the overlapping reservations held by other contexts. A store-conditional succeeds only while its own context still holds a reservation that covers the range it writes.

The write-permit answer is combinational and is given in the same cycle as the request. The reservation table changes on the next rising clock edge. A line-invalidate pulse empties the whole table. The table has one entry per context, so the contents can be seen directly on the outputs.

Top module: `llsc_resv_tracker`

## Requirements
- R1: After reset (active-low `rst_n`), every context's reservation is invalid.
- R2: `req_op` encodes 2'b00 as no operation, 2'b01 as load-linked, 2'b10 as store and 2'b11 as store-conditional. A legal load-linked sets the valid bit of context `req_ctx` and records `req_start` and `req_end` on the next edge. It replaces any earlier reservation of that same context.
- R3: A legal load-linked clears, on the next edge, every valid reservation of another context whose range overlaps the requested range.
- R4: A legal store clears, on the next edge, every valid reservation of another context whose range overlaps its own. The writer's own reservation is kept. Two ranges overlap when each start is not greater than the other's end, so ranges that share only one end byte overlap.
- R5: `wr_permit` is low only in a cycle that presents a failing store-conditional. Ordinary stores, load-linked requests, idle cycles and illegal requests always see it high.
- R6: A store-conditional succeeds when its context holds a valid reservation whose range contains the request range. On the next edge it clears that context's own reservation and every overlapping reservation of other contexts.
- R7: A failing store-conditional leaves every reservation unchanged.
- R8: `line_inv` clears all reservations on the next edge. It takes priority over a request in the same cycle.
- R9: When `req_valid` is low, the op is no operation, or `req_start` is greater than `req_end`, the reservation table stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 2 | Operation code (see R2) |
| req_ctx | input | CTX_W | Requesting context number |
| req_start | input | ADDR_W | First byte of the request range |
| req_end | input | ADDR_W | Last byte of the request range |
| line_inv | input | 1 | Invalidate the line, dropping all reservations |
| wr_permit | output | 1 | Write may proceed (same cycle) |
| resv_valid_o | output | NUM_CTX | Per-context reservation valid bits |
| resv_start_o | output | NUM_CTX*ADDR_W | Per-context reservation start, context 0 in the low bits |
| resv_end_o | output | NUM_CTX*ADDR_W | Per-context reservation end, context 0 in the low bits |

## Verification
The assertions assume that the inputs are driven to known values in every cycle after reset. They also assume that `req_ctx` always names an existing context, which holds by construction while NUM_CTX is a power of two. The bench changes its inputs only at falling edges and uses the default four contexts, so every context number it can drive names an entry. Some requests are deliberately illegal, with a start above the end, and the stable-state checks must hold for them as well.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_LL  = 2'b01,
        OP_ST  = 2'b10,
        OP_SC  = 2'b11
    } llsc_op_e;
endpackage

// File: rtl/llsc_req_decode.sv
module llsc_req_decode #(
    parameter int ADDR_W = 8
) (
    input  logic              valid,
    input  llsc_pkg::llsc_op_e op,
    input  logic [ADDR_W-1:0] start_a,
    input  logic [ADDR_W-1:0] end_a,
    output logic              is_ll,
    output logic              is_st,
    output logic              is_sc
);
    logic legal;
    always_comb begin
        legal = valid && (start_a <= end_a);
        is_ll = legal && (op == llsc_pkg::OP_LL);
        is_st = legal && (op == llsc_pkg::OP_ST);
        is_sc = legal && (op == llsc_pkg::OP_SC);
    end
endmodule

// File: rtl/llsc_range_cmp.sv
module llsc_range_cmp #(
    parameter int ADDR_W = 8
) (
    input  logic              ent_valid,
    input  logic [ADDR_W-1:0] ent_start,
    input  logic [ADDR_W-1:0] ent_end,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    output logic              overlap,
    output logic              covers
);
    always_comb begin
        overlap = ent_valid && (ent_start <= req_end) && (req_start <= ent_end);
        covers  = ent_valid && (ent_start <= req_start) && (req_end <= ent_end);
    end
endmodule

// File: rtl/llsc_resv_tracker.sv
module llsc_resv_tracker #(
    parameter int NUM_CTX = 4,
    parameter int ADDR_W  = 8,
    localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [1:0]                 req_op,
    input  logic [CTX_W-1:0]           req_ctx,
    input  logic [ADDR_W-1:0]          req_start,
    input  logic [ADDR_W-1:0]          req_end,
    input  logic                       line_inv,
    output logic                       wr_permit,
    output logic [NUM_CTX-1:0]         resv_valid_o,
    output logic [NUM_CTX*ADDR_W-1:0]  resv_start_o,
    output logic [NUM_CTX*ADDR_W-1:0]  resv_end_o
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } resv_t;

    typedef struct packed {
        resv_t [NUM_CTX-1:0] ent;
    } state_t;

    state_t state_d, state_q;

    logic is_ll, is_st, is_sc, sc_pass;
    logic [NUM_CTX-1:0] ovl, cov;

    llsc_req_decode #(.ADDR_W(ADDR_W)) dec_i (
        .valid   (req_valid),
        .op      (llsc_pkg::llsc_op_e'(req_op)),
        .start_a (req_start),
        .end_a   (req_end),
        .is_ll   (is_ll),
        .is_st   (is_st),
        .is_sc   (is_sc)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_cmp
        llsc_range_cmp #(.ADDR_W(ADDR_W)) cmp_i (
            .ent_valid (state_q.ent[g].vld),
            .ent_start (state_q.ent[g].lo),
            .ent_end   (state_q.ent[g].hi),
            .req_start (req_start),
            .req_end   (req_end),
            .overlap   (ovl[g]),
            .covers    (cov[g])
        );
        assign resv_valid_o[g]                   = state_q.ent[g].vld;
        assign resv_start_o[g*ADDR_W +: ADDR_W]  = state_q.ent[g].lo;
        assign resv_end_o[g*ADDR_W +: ADDR_W]    = state_q.ent[g].hi;
    end

    always_comb begin
        sc_pass   = is_sc && cov[req_ctx];
        wr_permit = !(is_sc && !sc_pass);
        state_d   = state_q;
        if (line_inv) begin
            for (int i = 0; i < NUM_CTX; i++) state_d.ent[i].vld = 1'b0;
        end else if (is_ll || is_st || sc_pass) begin
            for (int i = 0; i < NUM_CTX; i++) begin
                if ((CTX_W'(i) != req_ctx) && ovl[i]) state_d.ent[i].vld = 1'b0;
            end
            if (is_ll) begin
                state_d.ent[req_ctx].vld = 1'b1;
                state_d.ent[req_ctx].lo  = req_start;
                state_d.ent[req_ctx].hi  = req_end;
            end else if (sc_pass) begin
                state_d.ent[req_ctx].vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/llsc_resv_tracker_chk.sv
module llsc_resv_tracker_chk #(
    parameter int NUM_CTX = 4,
    parameter int ADDR_W  = 8,
    localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic [1:0]                req_op,
    input logic [CTX_W-1:0]          req_ctx,
    input logic [ADDR_W-1:0]         req_start,
    input logic [ADDR_W-1:0]         req_end,
    input logic                      line_inv,
    input logic                      wr_permit,
    input logic [NUM_CTX-1:0]        resv_valid_o,
    input logic [NUM_CTX*ADDR_W-1:0] resv_start_o
);
    p_st_permit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10) |-> wr_permit);

    p_inv_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_inv |=> (resv_valid_o == '0));

    p_ll_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01 && req_start <= req_end && !line_inv)
        |=> resv_valid_o[$past(req_ctx)]);

    p_sc_fail_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11 && !wr_permit && !line_inv)
        |=> $stable(resv_valid_o));

    p_idle_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !line_inv) |=> ($stable(resv_valid_o) && $stable(resv_start_o)));
endmodule

bind llsc_resv_tracker llsc_resv_tracker_chk #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_ctx      (req_ctx),
    .req_start    (req_start),
    .req_end      (req_end),
    .line_inv     (line_inv),
    .wr_permit    (wr_permit),
    .resv_valid_o (resv_valid_o),
    .resv_start_o (resv_start_o)
);

// File: tb/llsc_resv_tracker_tb.sv
module llsc_resv_tracker_tb_top;
    localparam int NC = 4;
    localparam int AW = 8;
    localparam int NV = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [1:0] req_ctx = 2'd0;
    logic [AW-1:0] req_start = '0, req_end = '0;
    logic line_inv = 1'b0;
    logic wr_permit;
    logic [NC-1:0] resv_valid_o;
    logic [NC*AW-1:0] resv_start_o, resv_end_o;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    llsc_resv_tracker #(.NUM_CTX(NC), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_ctx(req_ctx), .req_start(req_start), .req_end(req_end),
        .line_inv(line_inv), .wr_permit(wr_permit), .resv_valid_o(resv_valid_o),
        .resv_start_o(resv_start_o), .resv_end_o(resv_end_o)
    );

    // op, ctx, start, end, expected permit, expected valid mask after the edge
    typedef struct packed {
        logic [1:0]    op;
        logic [1:0]    ctx;
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
        logic          permit;
        logic [NC-1:0] mask;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'b01, 2'd0, 8'h10, 8'h17, 1'b1, 4'b0001}, // R2
        '{2'b01, 2'd1, 8'h20, 8'h27, 1'b1, 4'b0011}, // R2
        '{2'b01, 2'd2, 8'h30, 8'h3f, 1'b1, 4'b0111}, // R2
        '{2'b10, 2'd3, 8'h24, 8'h24, 1'b1, 4'b0101}, // R4 clears ctx1
        '{2'b11, 2'd1, 8'h20, 8'h27, 1'b0, 4'b0101}, // R5 R7
        '{2'b10, 2'd0, 8'h10, 8'h17, 1'b1, 4'b0101}, // R4 own kept
        '{2'b11, 2'd0, 8'h12, 8'h13, 1'b1, 4'b0100}, // R6
        '{2'b01, 2'd3, 8'h38, 8'h40, 1'b1, 4'b1000}, // R3
        '{2'b11, 2'd2, 8'h30, 8'h3f, 1'b0, 4'b1000}, // R7
        '{2'b01, 2'd1, 8'h40, 8'h48, 1'b1, 4'b0010}, // R3 edge touch
        '{2'b10, 2'd0, 8'h49, 8'h50, 1'b1, 4'b0010}, // R4 adjacent no overlap
        '{2'b11, 2'd1, 8'h40, 8'h49, 1'b0, 4'b0010}, // R6 not contained
        '{2'b01, 2'd1, 8'h44, 8'h45, 1'b1, 4'b0010}, // R2 replace
        '{2'b11, 2'd1, 8'h44, 8'h45, 1'b1, 4'b0000}, // R6
        '{2'b01, 2'd0, 8'h20, 8'h10, 1'b1, 4'b0000}, // R9 illegal range
        '{2'b11, 2'd0, 8'h00, 8'h01, 1'b0, 4'b0000}  // R5 no reservation
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [1:0] op, input logic [1:0] ctx,
                         input logic [AW-1:0] lo, input logic [AW-1:0] hi, input logic inv,
                         input string req, input logic exp_permit, input logic [NC-1:0] exp_mask);
        @(negedge clk);
        req_valid = v; req_op = op; req_ctx = ctx; req_start = lo; req_end = hi; line_inv = inv;
        #1;
        check({req, " permit"}, 32'(wr_permit), 32'(exp_permit));
        @(negedge clk);
        req_valid = 1'b0; line_inv = 1'b0;
        check({req, " mask"}, 32'(resv_valid_o), 32'(exp_mask));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 32'(resv_valid_o), 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++)
            issue(1'b1, VECS[i].op, VECS[i].ctx, VECS[i].lo, VECS[i].hi, 1'b0,
                  $sformatf("vec%0d", i), VECS[i].permit, VECS[i].mask);
        // R2 contents of the recorded range
        issue(1'b1, 2'b01, 2'd2, 8'h5a, 8'h6b, 1'b0, "R2 ll", 1'b1, 4'b0100);
        check("R2 start", 32'(resv_start_o[2*AW +: AW]), 32'h5a);
        check("R2 end",   32'(resv_end_o[2*AW +: AW]), 32'h6b);
        // R9 valid low and no-op leave the table
        issue(1'b0, 2'b01, 2'd3, 8'h00, 8'hff, 1'b0, "R9 idle", 1'b1, 4'b0100);
        issue(1'b1, 2'b00, 2'd2, 8'h5a, 8'h6b, 1'b0, "R9 nop", 1'b1, 4'b0100);
        issue(1'b1, 2'b10, 2'd0, 8'h70, 8'h6b, 1'b0, "R9 illegal st", 1'b1, 4'b0100);
        check("R9 start kept", 32'(resv_start_o[2*AW +: AW]), 32'h5a);
        // R8 invalidate, also over a same-cycle load-linked
        issue(1'b1, 2'b01, 2'd0, 8'h00, 8'h03, 1'b0, "R2 ll0", 1'b1, 4'b0101);
        issue(1'b0, 2'b00, 2'd0, 8'h00, 8'h00, 1'b1, "R8 inv", 1'b1, 4'b0000);
        issue(1'b1, 2'b01, 2'd1, 8'h00, 8'h03, 1'b1, "R8 inv prio", 1'b1, 4'b0000);
        // R5 stores and load-linked permitted even with no reservation
        issue(1'b1, 2'b10, 2'd3, 8'h00, 8'hff, 1'b0, "R5 store", 1'b1, 4'b0000);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                failures++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule